// File: doc/BRIEF.md
# Context-Configured ALU-Multiplier Cell

This block is a single coarse-grain processing cell meant to be tiled into a two-dimensional SIMD array. A 32-bit context word arrives together with a valid strobe. In one clock cycle the word sets every part of the cell:

- the source of each of the two operands;
- the arithmetic or logic operation;
- the output shift;
- the general register that takes the result;
- whether the result is offered to the data bus and to the express lane.

The cell holds four 16-bit general registers, a feedback register that captures the port-A operand, a sign flag, and a 32-bit output register. The datapath contains a signed 16x12 multiplier. Its 28-bit product goes into a 28-bit accumulator, so a multiply-accumulate completes in a single cycle.

The neighbour, quadrant-peer, lane and bus inputs are plain ports. The array that wires them together sits outside this block. While no valid context is present, or when the context carries an opcode with no assigned meaning, the cell keeps all of its state.

Top module: `ctx_cell`

## Requirements
- R1: After reset the output register, flag, bus-write and lane-write outputs are 0, and all four general registers and the feedback register hold 0.
- R2: Context fields are as follows:
  - bit 31: bus-write enable.
  - bit 30: lane-write enable.
  - bits 29:28: destination register.
  - bit 27: shift direction (1 = left, 0 = right).
  - bits 26:23: shift amount.
  - bits 22:19: port-A select.
  - bits 18:16: port-B select.
  - bits 15:12: opcode.
  - bits 11:0: signed constant.
- R3: Port-A select codes:
  - 0-3: general register 0-3.
  - 4: north. 5: south. 6: east. 7: west.
  - 8-11: quadrant peer 0-3 (`quad_in` slice k*16).
  - 12: express-lane input.
  - 13: `bus_a`.
  - 14: feedback register.
  - 15: cross-quadrant input.
- R4: Port-B select codes:
  - 0-3: general register 0-3.
  - 4: `bus_b`.
  - 5: north. 6: east. 7: west.
- R5: Operands are signed 16-bit values, sign-extended to 32 bits. The arithmetic opcodes are:
  - 0: A+B.
  - 1: A-B.
  - 2: |A-B|.
  - 8: A plus the sign-extended constant.
  - 9: A passed through.
- R6: The logic opcodes are 3 (AND), 4 (OR) and 5 (XOR). Each acts on the 16-bit operands, and its result is zero-extended to 32 bits.
- R7: Opcode 6 gives A times the signed 12-bit constant. The 28-bit product is sign-extended to 32 bits.
- R8: Opcode 7 adds that product to bits 27:0 of the current output register. The sum wraps at 28 bits and is sign-extended to 32 bits, all within one cycle.
- R9: The 32-bit result is shifted logically before it is stored, left or right by the shift amount. An amount of 0 leaves it unshifted.
- R10: On a valid context with an assigned opcode, all of these update on one clock edge:
  - the output register takes the shifted result;
  - the destination register takes bits 15:0 of the shifted result;
  - the feedback register takes the port-A operand;
  - the flag takes the sign bit of the port-A operand.
- R11: `bus_we` and `xl_we` equal context bits 31 and 30 for the cycle after a valid context with an assigned opcode. Otherwise they are 0.
- R12: With `ctx_valid` low, or with an opcode of 10-15, the output register, flag, general registers and feedback register keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctx_valid | input | 1 | Context word present this cycle |
| ctx_word | input | 32 | Context controlling this cycle's operation |
| nb_n | input | 16 | North neighbour output |
| nb_s | input | 16 | South neighbour output |
| nb_e | input | 16 | East neighbour output |
| nb_w | input | 16 | West neighbour output |
| quad_in | input | 64 | Four quadrant-peer outputs, peer k at bits k*16+15:k*16 |
| xl_in | input | 16 | Express-lane input |
| xq_in | input | 16 | Cross-quadrant input |
| bus_a | input | 16 | Data-bus operand for port A |
| bus_b | input | 16 | Data-bus operand for port B |
| out_q | output | 32 | Output register |
| flag_q | output | 1 | Sign of the last port-A operand |
| bus_we | output | 1 | Result offered to the data bus |
| xl_we | output | 1 | Result offered to the express lane |

## Verification
The bench builds the cell with its default widths: 16-bit data, a 12-bit constant, a 28-bit accumulator and a 32-bit output. At these widths every opcode value (the ten assigned ones and the six unused ones) can be swept against sign-boundary and pseudo-random operands. Every shift amount can be swept in both directions. Every select code of both operand multiplexers can be swept, and a long run of multiply-accumulate steps drives the accumulator through its 28-bit wrap. The general registers and the feedback register are read back through the port-A multiplexer, so their contents are observed at the output.

// File: rtl/ctx_cell.sv
module ctx_cell #(
  parameter int DW = 16,
  parameter int KW = 12,
  parameter int PW = 28,
  parameter int OW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctx_valid,
  input  logic [31:0]     ctx_word,
  input  logic [DW-1:0]   nb_n,
  input  logic [DW-1:0]   nb_s,
  input  logic [DW-1:0]   nb_e,
  input  logic [DW-1:0]   nb_w,
  input  logic [4*DW-1:0] quad_in,
  input  logic [DW-1:0]   xl_in,
  input  logic [DW-1:0]   xq_in,
  input  logic [DW-1:0]   bus_a,
  input  logic [DW-1:0]   bus_b,
  output logic [OW-1:0]   out_q,
  output logic            flag_q,
  output logic            bus_we,
  output logic            xl_we
);

  localparam int NREG = 4;
  localparam logic [3:0] OP_LAST = 4'd9;

  logic [3:0] op, sel_a, amt;
  logic [2:0] sel_b;
  logic [1:0] dst;
  logic       dir_left;
  logic [KW-1:0] kconst;

  assign op       = ctx_word[15:12];
  assign sel_a    = ctx_word[22:19];
  assign sel_b    = ctx_word[18:16];
  assign amt      = ctx_word[26:23];
  assign dir_left = ctx_word[27];
  assign dst      = ctx_word[29:28];
  assign kconst   = ctx_word[KW-1:0];

  logic [DW-1:0] rf [NREG];
  logic [DW-1:0] fb_q;
  logic [DW-1:0] opa, opb;

  always_comb begin
    case (sel_a)
      4'd0, 4'd1, 4'd2, 4'd3: opa = rf[sel_a[1:0]];
      4'd4:  opa = nb_n;
      4'd5:  opa = nb_s;
      4'd6:  opa = nb_e;
      4'd7:  opa = nb_w;
      4'd8, 4'd9, 4'd10, 4'd11: opa = quad_in[sel_a[1:0]*DW +: DW];
      4'd12: opa = xl_in;
      4'd13: opa = bus_a;
      4'd14: opa = fb_q;
      default: opa = xq_in;
    endcase
  end

  always_comb begin
    case (sel_b)
      3'd0, 3'd1, 3'd2, 3'd3: opb = rf[sel_b[1:0]];
      3'd4: opb = bus_b;
      3'd5: opb = nb_n;
      3'd6: opb = nb_e;
      default: opb = nb_w;
    endcase
  end

  logic signed [OW-1:0] ax, bx, kx, diff;
  logic signed [PW-1:0] prod, acc;
  logic [OW-1:0] res, shifted;
  logic legal, upd;

  assign ax   = OW'($signed(opa));
  assign bx   = OW'($signed(opb));
  assign kx   = OW'($signed(kconst));
  assign diff = ax - bx;
  assign prod = PW'($signed(opa)) * PW'($signed(kconst));
  assign acc  = out_q[PW-1:0] + prod;

  assign legal = (op <= OP_LAST);
  assign upd   = ctx_valid && legal;

  always_comb begin
    case (op)
      4'd0: res = ax + bx;
      4'd1: res = diff;
      4'd2: res = diff[OW-1] ? -diff : diff;
      4'd3: res = {{(OW-DW){1'b0}}, opa & opb};
      4'd4: res = {{(OW-DW){1'b0}}, opa | opb};
      4'd5: res = {{(OW-DW){1'b0}}, opa ^ opb};
      4'd6: res = {{(OW-PW){prod[PW-1]}}, prod};
      4'd7: res = {{(OW-PW){acc[PW-1]}}, acc};
      4'd8: res = ax + kx;
      4'd9: res = ax;
      default: res = out_q;
    endcase
  end

  assign shifted = dir_left ? (res << amt) : (res >> amt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q  <= '0;
      flag_q <= 1'b0;
      fb_q   <= '0;
      bus_we <= 1'b0;
      xl_we  <= 1'b0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      bus_we <= 1'b0;
      xl_we  <= 1'b0;
      if (upd) begin
        out_q   <= shifted;
        flag_q  <= opa[DW-1];
        fb_q    <= opa;
        rf[dst] <= shifted[DW-1:0];
        bus_we  <= ctx_word[31];
        xl_we   <= ctx_word[30];
      end
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctx_valid |=> $stable(out_q) && $stable(flag_q)); // R12

  AST_UNUSED_OP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_valid && op > OP_LAST) |=> $stable(out_q) && !bus_we && !xl_we); // R12

  AST_ENABLES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ctx_valid |=> !bus_we && !xl_we); // R11

  AST_PASS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_valid && op == 4'd9 && amt == 4'd0) |=> flag_q == out_q[OW-1]); // R10

  AST_LEFT_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && dir_left && amt != 4'd0) |=> !out_q[0]); // R9

  AST_RIGHT_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !dir_left && amt != 4'd0) |=> !out_q[OW-1]); // R9

  AST_ABSDIFF_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_valid && op == 4'd2 && amt == 4'd0) |=> !out_q[OW-1]); // R5

  AST_FB_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && sel_a == 4'd13) |=> fb_q == $past(bus_a)); // R10

endmodule

// File: tb/tb_ctx_cell.sv
module tb_ctx_cell;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, ctx_valid = 0;
  logic [31:0] ctx_word = '0;
  logic [15:0] nb_n = 0, nb_s = 0, nb_e = 0, nb_w = 0, xl_in = 0, xq_in = 0, bus_a = 0, bus_b = 0;
  logic [63:0] quad_in = '0;
  logic [31:0] out_q;
  logic flag_q, bus_we, xl_we;

  ctx_cell dut (.clk(clk), .rst_n(rst_n), .ctx_valid(ctx_valid), .ctx_word(ctx_word),
    .nb_n(nb_n), .nb_s(nb_s), .nb_e(nb_e), .nb_w(nb_w), .quad_in(quad_in),
    .xl_in(xl_in), .xq_in(xq_in), .bus_a(bus_a), .bus_b(bus_b),
    .out_q(out_q), .flag_q(flag_q), .bus_we(bus_we), .xl_we(xl_we));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] rng = 32'h1234_5678;

  logic [15:0] m_rf [4];
  logic [15:0] m_fb;
  logic [31:0] m_out;
  logic m_flag, m_bw, m_xw;

  function automatic logic [31:0] cw(input bit bw, input bit xw, input logic [1:0] dst,
      input bit left, input logic [3:0] amt, input logic [3:0] sa, input logic [2:0] sb,
      input logic [3:0] op, input logic [11:0] k);
    return {bw, xw, dst, left, amt, sa, sb, op, k};
  endfunction

  function automatic logic [15:0] pick_a(input logic [3:0] s);
    case (s)
      0, 1, 2, 3: return m_rf[s[1:0]];
      4: return nb_n;  5: return nb_s;  6: return nb_e;  7: return nb_w;
      8, 9, 10, 11: return quad_in[(s - 8) * 16 +: 16];
      12: return xl_in; 13: return bus_a; 14: return m_fb;
      default: return xq_in;
    endcase
  endfunction

  function automatic logic [15:0] pick_b(input logic [2:0] s);
    case (s)
      0, 1, 2, 3: return m_rf[s[1:0]];
      4: return bus_b; 5: return nb_n; 6: return nb_e;
      default: return nb_w;
    endcase
  endfunction

  function automatic logic [31:0] calc(input logic [3:0] op, input logic [15:0] a,
      input logic [15:0] b, input logic [11:0] k, input logic [31:0] o);
    logic signed [31:0] ax, bx, kx, d, t;
    logic signed [27:0] p, m;
    ax = $signed(a); bx = $signed(b); kx = $signed(k);
    p = $signed(a) * $signed(k);
    m = o[27:0] + p;
    d = ax - bx;
    case (op)
      0: return ax + bx;
      1: return d;
      2: return (d < 0) ? -d : d;
      3: return {16'h0, a & b};
      4: return {16'h0, a | b};
      5: return {16'h0, a ^ b};
      6: begin t = p; return t; end
      7: begin t = m; return t; end
      8: return ax + kx;
      default: return ax;
    endcase
  endfunction

  function automatic logic [15:0] nextv();
    rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
    return rng[15:0];
  endfunction

  task automatic run(input logic [31:0] w, input bit v, input string tag);
    logic [15:0] a, b;
    logic [31:0] r;
    a = pick_a(w[22:19]);
    b = pick_b(w[18:16]);
    ctx_word = w; ctx_valid = v;
    m_bw = 0; m_xw = 0;
    if (v && w[15:12] <= 4'd9) begin
      r = calc(w[15:12], a, b, w[11:0], m_out);
      r = w[27] ? (r << w[26:23]) : (r >> w[26:23]);
      m_out = r; m_flag = a[15]; m_fb = a; m_rf[w[29:28]] = r[15:0];
      m_bw = w[31]; m_xw = w[30];
    end
    @(negedge clk);
    ctx_valid = 0;
    checks++;
    if (out_q !== m_out || flag_q !== m_flag || bus_we !== m_bw || xl_we !== m_xw) begin
      fails++;
      $display("FAIL %s ctx=%h: out=%h flag=%b bw=%b xw=%b expected out=%h flag=%b bw=%b xw=%b",
        tag, w, out_q, flag_q, bus_we, xl_we, m_out, m_flag, m_bw, m_xw);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] edges [5];
    edges[0] = 16'h0000; edges[1] = 16'h0001; edges[2] = 16'h7FFF;
    edges[3] = 16'h8000; edges[4] = 16'hFFFF;
    for (int i = 0; i < 4; i++) m_rf[i] = 0;
    m_fb = 0; m_out = 0; m_flag = 0; m_bw = 0; m_xw = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state at the ports, then each register read back through port A
    checks++;
    if (out_q !== 0 || flag_q !== 0 || bus_we !== 0 || xl_we !== 0) begin
      fails++;
      $display("FAIL R1 reset: out=%h flag=%b bw=%b xw=%b expected all 0", out_q, flag_q, bus_we, xl_we);
    end
    for (int r = 0; r < 4; r++) run(cw(0, 0, 2'(r), 0, 0, 4'(r), 0, 4'd9, 0), 1, "R1 reg reset");
    bus_a = 16'hA5A5;
    run(cw(0, 0, 0, 0, 0, 4'd13, 0, 4'd9, 0), 1, "R10 fb load");
    run(cw(0, 0, 1, 0, 0, 4'd14, 0, 4'd9, 0), 1, "R10 fb read");

    // R2 R11: enable bits at positions 31 and 30
    for (int e = 0; e < 4; e++) run(cw(e[1], e[0], 0, 0, 0, 4'd13, 4, 4'd0, 0), 1, "R2 R11 enables");
    run(cw(1, 1, 0, 0, 0, 4'd13, 4, 4'd0, 0), 0, "R11 no valid");

    // R3: every port-A select
    nb_n = 16'h1111; nb_s = 16'h2222; nb_e = 16'h3333; nb_w = 16'h4444;
    quad_in = 64'h8888_7777_6666_5555; xl_in = 16'h9999; xq_in = 16'hCCCC;
    for (int r = 0; r < 4; r++) begin
      bus_a = 16'h0F00 + 16'(r);
      run(cw(0, 0, 2'(r), 0, 0, 4'd13, 0, 4'd9, 0), 1, "R10 reg load");
    end
    for (int s = 0; s < 16; s++) run(cw(0, 0, 0, 0, 0, 4'(s), 4, 4'd9, 0), 1, "R3 mux A");

    // R4: every port-B select, passed through AND with all-ones
    for (int r = 0; r < 4; r++) begin
      bus_a = 16'h5A00 + 16'(r);
      run(cw(0, 0, 2'(r), 0, 0, 4'd13, 0, 4'd9, 0), 1, "R10 reg load");
    end
    bus_a = 16'hFFFF; bus_b = 16'hBEEF;
    for (int s = 0; s < 8; s++) run(cw(0, 0, 3, 0, 0, 4'd13, 3'(s), 4'd3, 0), 1, "R4 mux B");

    // R5 R6 R7 R12: every opcode over edge and random operands
    for (int op = 0; op < 16; op++) begin
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++) begin
          bus_a = edges[i]; bus_b = edges[j];
          run(cw(0, 0, 2, 0, 0, 4'd13, 4, 4'(op), {edges[j][15:14], edges[i][9:0]}), 1, "R5 R6 R7 R12 edge ops");
        end
      for (int n = 0; n < 40; n++) begin
        bus_a = nextv(); bus_b = nextv();
        run(cw(0, 0, 2'(n), 0, 0, 4'd13, 4, 4'(op), nextv()), 1, "R5 R6 R7 R12 ops");
      end
    end

    // R8: long accumulation run through the 28-bit wrap
    run(cw(0, 0, 0, 0, 0, 4'd13, 4, 4'd0, 0), 1, "R8 clear");
    bus_a = 16'h7FFF;
    for (int n = 0; n < 40; n++) run(cw(0, 0, 0, 0, 0, 4'd13, 4, 4'd7, 12'h7FF), 1, "R8 mac wrap");
    bus_a = 16'h8000;
    for (int n = 0; n < 20; n++) run(cw(0, 0, 0, 0, 0, 4'd13, 4, 4'd7, 12'h7FF), 1, "R8 mac neg");
    for (int n = 0; n < 20; n++) begin
      bus_a = nextv();
      run(cw(0, 0, 1, 0, 0, 4'd13, 4, 4'd7, nextv()), 1, "R8 mac random");
    end

    // R9: every shift amount both ways
    for (int d = 0; d < 2; d++)
      for (int a = 0; a < 16; a++) begin
        bus_a = 16'h8001 ^ 16'(a);
        run(cw(0, 0, 3, d[0], 4'(a), 4'd13, 4, 4'd9, 0), 1, "R9 shift");
        run(cw(0, 0, 3, 0, 0, 4'd3, 4, 4'd9, 0), 1, "R9 R10 reg gets shifted low half");
      end

    // R12: idle cycles with garbage context keep everything
    for (int n = 0; n < 8; n++) run({nextv(), nextv()}, 0, "R12 idle hold");
    for (int r = 0; r < 4; r++) run(cw(0, 0, 0, 0, 0, 4'(r), 0, 4'd15, 0), 1, "R12 unused op");
    for (int r = 0; r < 4; r++) run(cw(0, 0, 2'(r), 0, 0, 4'(r), 0, 4'd9, 0), 1, "R12 regs kept");

    done = 1;
    summary();
    $finish;
  end
endmodule